// File: doc/BRIEF.md
# Virtual Processor Run-State Controller

This block keeps the run state of a fixed number of virtual processing elements (VPEs) in a multithreaded core. Each VPE has an enable bit owned by the block, an activation bit and a current-thread-activated bit supplied from outside, and a thread halt bit written through a write port. From these the block decides, every cycle, whether each VPE is active, halted, or parked waiting for an interrupt. It also reports whether the VPE has work to do.

Each VPE carries a four-state machine over two facts, halted and wake-pending. The states are `ST_RUN` (running, no wake pending), `ST_RUN_WAKE` (running, wake pending), `ST_SLEEP` (halted, no wake pending) and `ST_SLEEP_WAKE` (halted, wake pending). A sleep action moves any state to `ST_SLEEP`. A wake action moves `ST_RUN` to `ST_RUN_WAKE` and `ST_SLEEP` to `ST_SLEEP_WAKE`. A release, taken when a halted VPE shows has-work and no command touched it, moves `ST_SLEEP` to `ST_RUN` and `ST_SLEEP_WAKE` to `ST_RUN_WAKE`. A wake never clears the halted flag on its own. The has-work check decides when the VPE really runs.

Two broadcast commands act on every VPE other than the issuer: stop-others and start-others. Each returns the enable vector as it stood before the command. A WAIT pulse parks the issuing VPE.

Top module: `vpe_run_ctrl`

## Requirements
- R1: A VPE is active only when four conditions all hold: its enable bit is 1, its activation input is 1, its thread-activated input is 1, and its thread halt bit is 0. With the multithreading input at 1, clearing any one of them drops has-work to 0 in the same cycle.
- R2: A VPE is waiting-for-interrupt when it is halted and still active. A start-others command leaves such a VPE untouched: its enable bit and its wake-pending bit do not change.
- R3: A wake action sets only the wake-pending bit. The halted flag stays 1 in the cycle after the wake and clears one cycle later, when has-work is true.
- R4: A sleep action sets the halted flag and clears wake-pending on the next clock edge.
- R5: With the multithreading input at 1, has-work equals `active AND (wake-pending OR irq_pending)`. An inactive VPE shows 0 even while its interrupt is pending. A halted VPE that shows has-work and is not named by any command clears its halted flag on the next edge.
- R6: With the multithreading input at 0, has-work equals that VPE's `irq_pending` bit, and the release of R5 still applies.
- R7: A halt-bit write keeps only bit 0 of `halt_wr_data`. The stored bit is visible on `tc_halt`.
- R8: Writing 1 to the halt bit puts the VPE to sleep. Writing 0 raises a wake only if the VPE is active with the new halt bit and is not halted.
- R9: Stop-others clears the enable bit of every VPE except the one indexed by `cmd_vpe` and puts each of them to sleep. The issuer's enable bit is unchanged.
- R10: Start-others sets the enable bit and raises a wake on every VPE except the issuer and any VPE waiting for an interrupt.
- R11: A WAIT pulse sets the halted flag of VPE `wait_vpe` and clears its wake-pending bit.
- R12: After reset, VPE 0 is enabled and running and every other VPE is disabled and halted. No wake is pending and all halt bits are 0.
- R13: For a single VPE, commands in one cycle take effect in this order: stop-others first, then start-others, then the halt-bit write, then WAIT. Only the highest applicable one changes the run state. A halt-bit write always updates the stored bit.
- R14: One cycle after either broadcast command, `prev_ctrl_valid` is 1 for one cycle. `prev_ctrl` then holds the enable vector from before the command, and keeps that value until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mt_feature | input | 1 | Multithreading feature present |
| vpe_activate | input | NUM_VPE | Per-VPE activation bit |
| tc_activated | input | NUM_VPE | Per-VPE current thread activated bit |
| irq_pending | input | NUM_VPE | Per-VPE pending interrupt |
| halt_wr_en | input | 1 | Halt-bit write strobe |
| halt_wr_vpe | input | IDX_W | VPE targeted by the halt-bit write |
| halt_wr_data | input | DATA_W | Halt-bit write data (bit 0 kept) |
| wait_en | input | 1 | WAIT instruction pulse |
| wait_vpe | input | IDX_W | VPE issuing WAIT |
| stop_others | input | 1 | Stop-others command |
| start_others | input | 1 | Start-others command |
| cmd_vpe | input | IDX_W | Issuer of the broadcast command |
| vpe_enable | output | NUM_VPE | Per-VPE enable bits |
| tc_halt | output | NUM_VPE | Stored thread halt bits |
| vpe_halted | output | NUM_VPE | Per-VPE halted flag |
| wake_pending | output | NUM_VPE | Per-VPE wake-request bit |
| has_work | output | NUM_VPE | Per-VPE has-work result |
| prev_ctrl | output | NUM_VPE | Enable vector from before the last broadcast |
| prev_ctrl_valid | output | 1 | One-cycle flag after a broadcast |

## Verification
The enable, halt, halted and wake-pending bits, along with `prev_ctrl` and its flag, are registered. Each reflects a command one clock edge after the command is sampled. `has_work` is combinational from that state and the level inputs, so it changes as soon as the inputs do. A release therefore shows up as a halted flag that clears two edges after a wake command: one edge for the wake, one for the release. The reference model advances on each rising edge. It is compared 2 ns later, while the inputs, which change only on falling edges, are still stable. The directed checks sample 1 ns after the falling edge that follows the edge which applied the stimulus.

// File: rtl/vpe_run_pkg.sv
package vpe_run_pkg;

    // Run state per VPE: halted flag x wake-pending bit.
    typedef enum logic [1:0] {
        ST_RUN        = 2'b00,
        ST_RUN_WAKE   = 2'b01,
        ST_SLEEP      = 2'b10,
        ST_SLEEP_WAKE = 2'b11
    } vpe_state_e;

endpackage

// File: rtl/vpe_cmd_dec.sv
module vpe_cmd_dec #(
    parameter int NUM_VPE = 4,
    parameter int IDX_W   = 2
) (
    input  logic               stop_others,
    input  logic               start_others,
    input  logic [IDX_W-1:0]   cmd_vpe,
    input  logic               halt_wr_en,
    input  logic [IDX_W-1:0]   halt_wr_vpe,
    input  logic               wait_en,
    input  logic [IDX_W-1:0]   wait_vpe,
    output logic [NUM_VPE-1:0] stop_vec,
    output logic [NUM_VPE-1:0] start_vec,
    output logic [NUM_VPE-1:0] hwr_vec,
    output logic [NUM_VPE-1:0] wait_vec
);

    // Per-VPE one-hot strobes; broadcasts exclude the issuer.
    for (genvar gi = 0; gi < NUM_VPE; gi++) begin : g_dec
        logic is_issuer;
        assign is_issuer     = (cmd_vpe == IDX_W'(gi));
        assign stop_vec[gi]  = stop_others  && !is_issuer;
        assign start_vec[gi] = start_others && !is_issuer;
        assign hwr_vec[gi]   = halt_wr_en   && (halt_wr_vpe == IDX_W'(gi));
        assign wait_vec[gi]  = wait_en      && (wait_vpe    == IDX_W'(gi));
    end

endmodule

// File: rtl/vpe_slot.sv
module vpe_slot
    import vpe_run_pkg::*;
#(
    parameter bit BOOT_RUN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mt_en,
    input  logic activate,
    input  logic tc_act,
    input  logic irq,
    input  logic ev_stop,
    input  logic ev_start,
    input  logic hw_we,
    input  logic hw_bit,
    input  logic wait_req,
    output logic en,
    output logic tc_halt,
    output logic halted,
    output logic wake_req,
    output logic has_work
);

    localparam vpe_state_e BOOT_STATE = BOOT_RUN ? ST_RUN : ST_SLEEP;

    vpe_state_e st_q, st_d;
    logic       en_q, th_q;
    logic       active, in_wfi;
    logic       take_stop, take_start, take_hw, take_wait, no_cmd;
    logic       go_sleep, go_wake, go_release;

    // Output decode of the state.
    always_comb begin
        unique case (st_q)
            ST_RUN:        begin halted = 1'b0; wake_req = 1'b0; end
            ST_RUN_WAKE:   begin halted = 1'b0; wake_req = 1'b1; end
            ST_SLEEP:      begin halted = 1'b1; wake_req = 1'b0; end
            ST_SLEEP_WAKE: begin halted = 1'b1; wake_req = 1'b1; end
            default:       begin halted = 1'b1; wake_req = 1'b0; end
        endcase
    end

    assign en      = en_q;
    assign tc_halt = th_q;
    assign active  = en_q && activate && tc_act && !th_q;
    assign in_wfi  = halted && active;
    assign has_work = mt_en ? (active && (wake_req || irq)) : irq;

    // Command priority: stop, start, halt write, wait.
    assign take_stop  = ev_stop;
    assign take_start = !ev_stop && ev_start && !in_wfi;
    assign take_hw    = !take_stop && !take_start && hw_we;
    assign take_wait  = !take_stop && !take_start && !hw_we && wait_req;
    assign no_cmd     = !take_stop && !take_start && !hw_we && !wait_req;

    assign go_sleep   = take_stop || (take_hw && hw_bit) || take_wait;
    assign go_wake    = take_start ||
                        (take_hw && !hw_bit && en_q && activate && tc_act && !halted);
    assign go_release = no_cmd && halted && has_work;

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (go_sleep)      st_d = ST_SLEEP;
                else if (go_wake)  st_d = ST_RUN_WAKE;
            end
            ST_RUN_WAKE: begin
                if (go_sleep)      st_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (go_wake)         st_d = ST_SLEEP_WAKE;
                else if (go_release) st_d = ST_RUN;
            end
            ST_SLEEP_WAKE: begin
                if (go_sleep)        st_d = ST_SLEEP;
                else if (go_release) st_d = ST_RUN_WAKE;
            end
            default: st_d = ST_SLEEP;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BOOT_STATE;
            en_q <= BOOT_RUN;
            th_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (take_stop)       en_q <= 1'b0;
            else if (take_start) en_q <= 1'b1;
            if (hw_we)           th_q <= hw_bit;
        end
    end

    AST_SLEEP_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
        go_sleep |=> (halted && !wake_req)); // R4

    AST_WAKE_KEEPS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (take_start && halted) |=> (halted && wake_req)); // R3

    AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && has_work && !ev_stop && !ev_start && !hw_we && !wait_req) |=> !halted); // R5

    AST_INACTIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_en && !en_q) |-> !has_work); // R5

    AST_WFI_UNDISTURBED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !ev_stop && in_wfi) |=> (en_q == $past(en_q))); // R2

endmodule

// File: rtl/vpe_run_ctrl.sv
module vpe_run_ctrl #(
    parameter  int NUM_VPE = 4,
    parameter  int DATA_W  = 32,
    localparam int IDX_W   = (NUM_VPE > 1) ? $clog2(NUM_VPE) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mt_feature,
    input  logic [NUM_VPE-1:0] vpe_activate,
    input  logic [NUM_VPE-1:0] tc_activated,
    input  logic [NUM_VPE-1:0] irq_pending,
    input  logic               halt_wr_en,
    input  logic [IDX_W-1:0]   halt_wr_vpe,
    input  logic [DATA_W-1:0]  halt_wr_data,
    input  logic               wait_en,
    input  logic [IDX_W-1:0]   wait_vpe,
    input  logic               stop_others,
    input  logic               start_others,
    input  logic [IDX_W-1:0]   cmd_vpe,
    output logic [NUM_VPE-1:0] vpe_enable,
    output logic [NUM_VPE-1:0] tc_halt,
    output logic [NUM_VPE-1:0] vpe_halted,
    output logic [NUM_VPE-1:0] wake_pending,
    output logic [NUM_VPE-1:0] has_work,
    output logic [NUM_VPE-1:0] prev_ctrl,
    output logic               prev_ctrl_valid
);

    logic [NUM_VPE-1:0] stop_vec, start_vec, hwr_vec, wait_vec;
    logic               bcast;

    vpe_cmd_dec #(.NUM_VPE(NUM_VPE), .IDX_W(IDX_W)) u_dec (
        .stop_others (stop_others),
        .start_others(start_others),
        .cmd_vpe     (cmd_vpe),
        .halt_wr_en  (halt_wr_en),
        .halt_wr_vpe (halt_wr_vpe),
        .wait_en     (wait_en),
        .wait_vpe    (wait_vpe),
        .stop_vec    (stop_vec),
        .start_vec   (start_vec),
        .hwr_vec     (hwr_vec),
        .wait_vec    (wait_vec)
    );

    for (genvar gv = 0; gv < NUM_VPE; gv++) begin : g_vpe
        vpe_slot #(.BOOT_RUN(gv == 0)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .mt_en   (mt_feature),
            .activate(vpe_activate[gv]),
            .tc_act  (tc_activated[gv]),
            .irq     (irq_pending[gv]),
            .ev_stop (stop_vec[gv]),
            .ev_start(start_vec[gv]),
            .hw_we   (hwr_vec[gv]),
            .hw_bit  (halt_wr_data[0]),
            .wait_req(wait_vec[gv]),
            .en      (vpe_enable[gv]),
            .tc_halt (tc_halt[gv]),
            .halted  (vpe_halted[gv]),
            .wake_req(wake_pending[gv]),
            .has_work(has_work[gv])
        );
    end

    assign bcast = stop_others || start_others;

    // Previous-control return register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ctrl       <= '0;
            prev_ctrl_valid <= 1'b0;
        end else begin
            prev_ctrl_valid <= bcast;
            if (bcast) prev_ctrl <= vpe_enable;
        end
    end

    AST_PREV_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        bcast |=> (prev_ctrl_valid && prev_ctrl == $past(vpe_enable))); // R14

    AST_ISSUER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        bcast |=> (vpe_enable[$past(cmd_vpe)] == $past(vpe_enable[cmd_vpe]))); // R9

endmodule

// File: tb/vpe_run_ctrl_test.sv
`timescale 1ns/1ps
module vpe_run_ctrl_test;

    localparam int N  = 4;
    localparam int DW = 32;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mt_feature = 1'b1;
    logic [N-1:0]  vpe_activate = '1;
    logic [N-1:0]  tc_activated = '1;
    logic [N-1:0]  irq_pending = '0;
    logic          halt_wr_en = 1'b0;
    logic [IW-1:0] halt_wr_vpe = '0;
    logic [DW-1:0] halt_wr_data = '0;
    logic          wait_en = 1'b0;
    logic [IW-1:0] wait_vpe = '0;
    logic          stop_others = 1'b0;
    logic          start_others = 1'b0;
    logic [IW-1:0] cmd_vpe = '0;
    logic [N-1:0]  vpe_enable, tc_halt, vpe_halted, wake_pending, has_work, prev_ctrl;
    logic          prev_ctrl_valid;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk; // 125 MHz

    vpe_run_ctrl #(.NUM_VPE(N), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .mt_feature(mt_feature),
        .vpe_activate(vpe_activate), .tc_activated(tc_activated),
        .irq_pending(irq_pending), .halt_wr_en(halt_wr_en),
        .halt_wr_vpe(halt_wr_vpe), .halt_wr_data(halt_wr_data),
        .wait_en(wait_en), .wait_vpe(wait_vpe),
        .stop_others(stop_others), .start_others(start_others),
        .cmd_vpe(cmd_vpe), .vpe_enable(vpe_enable), .tc_halt(tc_halt),
        .vpe_halted(vpe_halted), .wake_pending(wake_pending),
        .has_work(has_work), .prev_ctrl(prev_ctrl),
        .prev_ctrl_valid(prev_ctrl_valid)
    );

    // Behavioural reference model.
    bit m_en[N], m_th[N], m_h[N], m_w[N];
    bit [N-1:0] m_prev;
    bit m_pv;

    function automatic bit m_active(int i);
        return m_en[i] && vpe_activate[i] && tc_activated[i] && !m_th[i];
    endfunction

    function automatic bit m_work(int i);
        if (!mt_feature) return irq_pending[i];
        return m_active(i) && (m_w[i] || irq_pending[i]);
    endfunction

    function automatic bit [N-1:0] m_en_vec();
        bit [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_en[i];
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_en[i] = (i == 0); m_th[i] = 0; m_h[i] = (i != 0); m_w[i] = 0;
            end
            m_prev = '0; m_pv = 0;
        end else begin
            bit n_en[N], n_th[N], n_h[N], n_w[N];
            for (int i = 0; i < N; i++) begin
                bit wfi;
                n_en[i] = m_en[i]; n_th[i] = m_th[i]; n_h[i] = m_h[i]; n_w[i] = m_w[i];
                wfi = m_h[i] && m_active(i);
                if (halt_wr_en && halt_wr_vpe == IW'(i)) n_th[i] = halt_wr_data[0];
                if (stop_others && cmd_vpe != IW'(i)) begin
                    n_en[i] = 0; n_h[i] = 1; n_w[i] = 0;
                end else if (start_others && cmd_vpe != IW'(i) && !wfi) begin
                    n_en[i] = 1; n_w[i] = 1;
                end else if (halt_wr_en && halt_wr_vpe == IW'(i)) begin
                    if (halt_wr_data[0]) begin
                        n_h[i] = 1; n_w[i] = 0;
                    end else if (m_en[i] && vpe_activate[i] && tc_activated[i] && !m_h[i]) begin
                        n_w[i] = 1;
                    end
                end else if (wait_en && wait_vpe == IW'(i)) begin
                    n_h[i] = 1; n_w[i] = 0;
                end else if (m_h[i] && m_work(i)) begin
                    n_h[i] = 0;
                end
            end
            m_pv = stop_others || start_others;
            if (m_pv) m_prev = m_en_vec();
            for (int i = 0; i < N; i++) begin
                m_en[i] = n_en[i]; m_th[i] = n_th[i]; m_h[i] = n_h[i]; m_w[i] = n_w[i];
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle compare against the model, 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                chk("R4 model halted", 32'(vpe_halted[i]), 32'(m_h[i]));
                chk("R3 model wake", 32'(wake_pending[i]), 32'(m_w[i]));
                chk("R5 model has_work", 32'(has_work[i]), 32'(m_work(i)));
                chk("R9 model enable", 32'(vpe_enable[i]), 32'(m_en[i]));
                chk("R7 model halt bit", 32'(tc_halt[i]), 32'(m_th[i]));
            end
            chk("R14 model prev valid", 32'(prev_ctrl_valid), 32'(m_pv));
            chk("R14 model prev", 32'(prev_ctrl), 32'(m_prev));
        end
    end

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) nxt();
        rst_n = 1'b1;
        settle();
        chk("R12 halted", 32'(vpe_halted), 32'b1110);
        chk("R12 wake", 32'(wake_pending), 32'b0000);
        chk("R12 enable", 32'(vpe_enable), 32'b0001);
        chk("R12 halt bits", 32'(tc_halt), 32'b0000);

        nxt(); irq_pending = 4'b0001; settle();
        chk("R5 irq on active", 32'(has_work), 32'b0001);
        irq_pending = 4'b0010; settle();
        chk("R5 irq on inactive", 32'(has_work), 32'b0000);
        irq_pending = '0;

        wait_en = 1'b1; wait_vpe = 0;
        nxt(); wait_en = 1'b0; settle();
        chk("R11 wait halts", 32'(vpe_halted), 32'b1111);
        chk("R11 wait wake", 32'(wake_pending[0]), 32'b0);

        irq_pending = 4'b0001;
        nxt(); irq_pending = '0; settle();
        chk("R5 release", 32'(vpe_halted[0]), 32'b0);

        start_others = 1'b1; cmd_vpe = 0;
        nxt(); start_others = 1'b0; settle();
        chk("R10 enable", 32'(vpe_enable), 32'b1111);
        chk("R10 wake", 32'(wake_pending), 32'b1110);
        chk("R3 still halted", 32'(vpe_halted), 32'b1110);
        chk("R14 prev", 32'(prev_ctrl), 32'b0001);
        chk("R14 valid", 32'(prev_ctrl_valid), 32'b1);
        nxt(); settle();
        chk("R3 released", 32'(vpe_halted), 32'b0000);
        chk("R14 valid drop", 32'(prev_ctrl_valid), 32'b0);

        wait_en = 1'b1; wait_vpe = 2;
        nxt(); wait_en = 1'b0;
        start_others = 1'b1; cmd_vpe = 1;
        nxt(); start_others = 1'b0; settle();
        chk("R2 wfi skipped wake", 32'(wake_pending), 32'b1011);
        chk("R2 wfi halted", 32'(vpe_halted), 32'b0100);

        halt_wr_en = 1'b1; halt_wr_vpe = 3; halt_wr_data = 32'hFFFF_FFFE;
        nxt(); settle();
        chk("R7 bit0 only", 32'(tc_halt[3]), 32'b0);
        halt_wr_data = 32'h0000_0003;
        nxt(); settle();
        chk("R8 write 1 halts", 32'(vpe_halted[3]), 32'b1);
        chk("R8 write 1 clears wake", 32'(wake_pending[3]), 32'b0);
        halt_wr_data = 32'h0;
        nxt(); halt_wr_en = 1'b0; settle();
        chk("R8 write 0 halted no wake", 32'(wake_pending[3]), 32'b0);
        nxt(); settle();
        chk("R8 stays halted", 32'(vpe_halted[3]), 32'b1);

        tc_activated[1] = 1'b0; settle();
        chk("R1 thread inactive", 32'(has_work[1]), 32'b0);
        tc_activated[1] = 1'b1; vpe_activate[1] = 1'b0; settle();
        chk("R1 activation clear", 32'(has_work[1]), 32'b0);
        vpe_activate[1] = 1'b1; settle();
        chk("R1 all set", 32'(has_work[1]), 32'b1);

        stop_others = 1'b1; cmd_vpe = 2;
        nxt(); stop_others = 1'b0; settle();
        chk("R9 enable", 32'(vpe_enable), 32'b0100);
        chk("R9 halted", 32'(vpe_halted), 32'b1111);
        chk("R9 wake", 32'(wake_pending), 32'b0000);
        chk("R14 prev stop", 32'(prev_ctrl), 32'b1111);

        mt_feature = 1'b0; irq_pending = 4'b0001; settle();
        chk("R6 irq only", 32'(has_work), 32'b0001);
        nxt(); settle();
        chk("R6 release", 32'(vpe_halted), 32'b1110);
        mt_feature = 1'b1; settle();
        chk("R5 disabled no work", 32'(has_work[0]), 32'b0);
        irq_pending = '0;

        stop_others = 1'b1; start_others = 1'b1; cmd_vpe = 0;
        wait_en = 1'b1; wait_vpe = 2;
        halt_wr_en = 1'b1; halt_wr_vpe = 1; halt_wr_data = 32'h1;
        nxt(); stop_others = 1'b0; halt_wr_en = 1'b0; wait_vpe = 1; settle();
        chk("R13 stop wins enable", 32'(vpe_enable), 32'b0000);
        chk("R13 stop wins halted", 32'(vpe_halted), 32'b1110);
        chk("R13 halt bit stored", 32'(tc_halt[1]), 32'b1);
        nxt(); start_others = 1'b0; wait_en = 1'b0; settle();
        chk("R13 start beats wait", 32'(wake_pending[1]), 32'b1);

        repeat (4) nxt();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule